// File: doc/BRIEF.md
# Burst Address Sequencer with Dual Strobes

This block produces the word address that a synchronous burst memory port uses on each clock. A burst starts when one of two active-low address strobes is sampled while the device is selected. One strobe is meant for a processor and the other for a cache controller. The block then walks through a four-word group, holds its place, or goes idle, as directed by an active-low advance input. The upper address bits never change inside a group. Only the two low bits follow either an interleaved (XOR) order or a linear (wrapping increment) order, chosen by a static mode input.

The device counts as selected only when all three enable inputs agree. The processor strobe is honoured only while the primary enable is active, and a load through that strobe is always a read. A load through the controller strobe takes its read or write direction from the write control. A strobe seen while the device is not selected puts the block into an idle (deselected) state. It leaves that state only through a new load. When both strobes are inactive, the enables play no part and the advance input alone decides between stepping and holding.

Top module: `burst_addr_seq`

## Requirements
- R1: The device is selected only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. If any one of these disagrees, a sampled strobe yields deselect and never a load.
- R2: If `en_a_n`=0, `strb_cpu_n`=0 and the device is selected, then at that edge `cur_addr` becomes `ext_addr`, `cyc_valid`=1, `desel`=0 and `cyc_write`=0, whatever `wr_n` is.
- R3: If the processor strobe is not honoured, `strb_ctl_n`=0 and the device is selected, then at that edge `cur_addr` becomes `ext_addr` and `cyc_write` becomes the inverse of `wr_n` (0 means write).
- R4: A strobe sampled without selection sets `desel`=1 and `cyc_valid`=0. The beat position goes back to the start, so `cur_addr` shows the last start address. This state persists through any number of advance or hold cycles until the next load.
- R5: While `en_a_n`=1, `strb_cpu_n` has no effect. With `strb_ctl_n`=1 the block steps or holds exactly as if both strobes were high.
- R6: With `seq_il`=1, after k steps the two low bits of `cur_addr` equal the start low bits XOR (k mod 4).
- R7: With `seq_il`=0, after k steps the two low bits equal (start low bits + k) mod 4.
- R8: With both strobes inactive and `adv_n`=1, `cur_addr`, `cyc_valid` and `cyc_write` keep their values.
- R9: Bits above bit 1 of `cur_addr` stay at the start value during a burst. After four steps the address is back at the start address.
- R10: While `rst_n` is low at a clock edge, the block is deselected: `desel`=1, `cyc_valid`=0, `cyc_write`=0, `cur_addr`=0.
- R11: With both strobes inactive, the three enable inputs do not affect stepping or holding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_addr | input | ADDR_W | Burst start address |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Advance, low steps and high holds |
| seq_il | input | 1 | Order select: 1 interleaved, 0 linear |
| en_a_n | input | 1 | Primary enable, active low |
| en_b | input | 1 | Second enable, active high |
| en_c_n | input | 1 | Third enable, active low |
| wr_n | input | 1 | Write control for controller loads, 0 means write |
| cur_addr | output | ADDR_W | Address of the current beat |
| cyc_valid | output | 1 | A burst is active |
| cyc_write | output | 1 | Active burst is a write |
| desel | output | 1 | Block is deselected |

## Verification
The hardest situations to reach are those where the strobes and enables disagree. These include a processor strobe with the primary enable off, which must fall through to step or hold, and a strobe with only one enable wrong. Both must be shown while a burst is partly advanced, so that the difference between continuing and deselecting shows on `cur_addr`. Directed sequences first advance a burst to a mid beat and then apply each mixed combination. A long random phase then mixes strobes, enables and advance. Every clock is compared against a behavioural model, and the order select changes only on load cycles.

// File: rtl/bseq_pkg.sv
// Shared definitions for the burst address sequencer.
package bseq_pkg;
    // Action chosen for one clock edge.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_DESEL = 2'd3
    } bseq_op_t;
endpackage

// File: rtl/bseq_decode.sv
// Strobe/enable decoder: picks the action for the coming edge.
// Assumes: all inputs are synchronous to clk. The processor strobe counts
// only while the primary enable is active. A processor load is always a read.
module bseq_decode
    import bseq_pkg::*;
(
    input  logic     strb_cpu_n,
    input  logic     strb_ctl_n,
    input  logic     adv_n,
    input  logic     en_a_n,
    input  logic     en_b,
    input  logic     en_c_n,
    input  logic     wr_n,
    output bseq_op_t op,
    output logic     load_wr
);
    logic sel;

    // Select needs all three enables; strobe priority then picks the action.
    always_comb begin
        sel     = !en_a_n && en_b && !en_c_n;
        op      = OP_HOLD;
        load_wr = 1'b0;
        if (!en_a_n && !strb_cpu_n) begin
            op = sel ? OP_LOAD : OP_DESEL;
        end else if (!strb_ctl_n) begin
            op      = sel ? OP_LOAD : OP_DESEL;
            load_wr = sel && !wr_n;
        end else begin
            op = adv_n ? OP_HOLD : OP_STEP;
        end
    end
endmodule

// File: rtl/bseq_state.sv
// Burst state registers: start address, beat count, deselect and direction.
// Assumes: op comes from bseq_decode. Steps and holds are ignored while
// deselected; only a load leaves that state.
module bseq_state
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bseq_op_t          op,
    input  logic              load_wr,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] base_q,
    output logic [BEAT_W-1:0] beat_q,
    output logic              desel_q,
    output logic              wr_q
);
    // Update the burst state on each edge according to the chosen action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            beat_q  <= '0;
            desel_q <= 1'b1;
            wr_q    <= 1'b0;
        end else begin
            unique case (op)
                OP_LOAD: begin
                    base_q  <= ext_addr;
                    beat_q  <= '0;
                    desel_q <= 1'b0;
                    wr_q    <= load_wr;
                end
                OP_DESEL: begin
                    beat_q  <= '0;
                    desel_q <= 1'b1;
                    wr_q    <= 1'b0;
                end
                OP_STEP: begin
                    if (!desel_q) beat_q <= beat_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R4
    desel_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desel_q && op != OP_LOAD) |=> desel_q);

    // R2
    load_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (base_q == $past(ext_addr) && beat_q == '0 && !desel_q));
endmodule

// File: rtl/bseq_map.sv
// Address mapper: joins the fixed upper start bits with the beat's low bits.
// Assumes: BEAT_W < ADDR_W. The order select is combinational and static.
module bseq_map #(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic [ADDR_W-1:0] base_q,
    input  logic [BEAT_W-1:0] beat_q,
    input  logic              seq_il,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic [BEAT_W-1:0] lo;

    // Low bits: XOR order when interleaved, wrapping add when linear.
    always_comb begin
        lo = seq_il ? (base_q[BEAT_W-1:0] ^ beat_q)
                    : (base_q[BEAT_W-1:0] + beat_q);
    end

    generate
        if (HI_W > 0) begin : g_hi
            assign addr = {base_q[ADDR_W-1:BEAT_W], lo};
        end else begin : g_lo_only
            assign addr = lo;
        end
    endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
// Burst address sequencer top: decoder, state registers and address mapper.
// Assumes: synchronous active-low reset. seq_il changes only on load cycles.
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              seq_il,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              wr_n,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cyc_valid,
    output logic              cyc_write,
    output logic              desel
);
    bseq_op_t          op;
    logic              load_wr;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic              desel_q;
    logic              wr_q;

    bseq_decode u_dec (
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .adv_n      (adv_n),
        .en_a_n     (en_a_n),
        .en_b       (en_b),
        .en_c_n     (en_c_n),
        .wr_n       (wr_n),
        .op         (op),
        .load_wr    (load_wr)
    );

    bseq_state #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .load_wr  (load_wr),
        .ext_addr (ext_addr),
        .base_q   (base_q),
        .beat_q   (beat_q),
        .desel_q  (desel_q),
        .wr_q     (wr_q)
    );

    bseq_map #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_map (
        .base_q (base_q),
        .beat_q (beat_q),
        .seq_il (seq_il),
        .addr   (cur_addr)
    );

    assign cyc_valid = !desel_q;
    assign cyc_write = wr_q;
    assign desel     = desel_q;

    // R8
    hold_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> ($stable(base_q) && $stable(beat_q) && $stable(cyc_write)));

    // R9
    step_upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP) |=> $stable(base_q));

    // R2
    cpu_load_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_cpu_n && !en_a_n && en_b && !en_c_n) |=> (!cyc_write && cyc_valid));

    // R1
    unselected_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!strb_ctl_n || (!strb_cpu_n && !en_a_n)) && !(!en_a_n && en_b && !en_c_n))
        |=> (desel && !cyc_valid));
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1, seq_il = 1'b1;
    logic          en_a_n = 1'b1, en_b = 1'b0, en_c_n = 1'b1, wr_n = 1'b1;
    logic [AW-1:0] cur_addr;
    logic          cyc_valid, cyc_write, desel;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural model state
    int    m_base = 0, m_beat = 0;
    bit    m_des = 1, m_wr = 0;
    string tag = "R10";

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
        .seq_il(seq_il), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .wr_n(wr_n), .cur_addr(cur_addr), .cyc_valid(cyc_valid),
        .cyc_write(cyc_write), .desel(desel)
    );

    // Reference model, updated from the inputs sampled at each edge.
    always @(posedge clk) begin
        bit sel;
        if (!rst_n) begin
            m_base = 0; m_beat = 0; m_des = 1; m_wr = 0; tag = "R10";
        end else begin
            sel = !en_a_n && en_b && !en_c_n;
            if (!en_a_n && !strb_cpu_n) begin
                if (sel) begin
                    m_base = int'(ext_addr); m_beat = 0; m_des = 0; m_wr = 0; tag = "R2";
                end else begin
                    m_beat = 0; m_des = 1; m_wr = 0; tag = "R1";
                end
            end else if (!strb_ctl_n) begin
                if (sel) begin
                    m_base = int'(ext_addr); m_beat = 0; m_des = 0; m_wr = !wr_n; tag = "R3";
                end else begin
                    m_beat = 0; m_des = 1; m_wr = 0; tag = "R4";
                end
            end else if (m_des) begin
                tag = "R4";
            end else begin
                if (!adv_n) begin
                    m_beat = (m_beat + 1) % 4;
                    tag = seq_il ? "R6" : "R7";
                end else tag = "R8";
                if (!strb_cpu_n) tag = "R5";
                else if (!sel) tag = "R11";
            end
        end
    end

    function automatic int exp_addr();
        int lo;
        lo = m_base % 4;
        lo = seq_il ? (lo ^ m_beat) : ((lo + m_beat) % 4);
        return (m_base / 4) * 4 + lo;
    endfunction

    task automatic check(input string req, input bit ok, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Compare every port against the model.
    task automatic compare();
        int ea;
        ea = exp_addr();
        check(tag, int'(cur_addr) == ea, int'(cur_addr), ea);
        check(tag, {cyc_valid, desel, cyc_write} == {!m_des, m_des, m_wr},
              {cyc_valid, desel, cyc_write}, {!m_des, m_des, m_wr});
    endtask

    // Drive one cycle's inputs, wait past the edge, then compare.
    task automatic cyc(input bit cpu, input bit ctl, input bit adv,
                       input bit ea, input bit eb, input bit ec,
                       input bit w, input int a);
        strb_cpu_n = cpu; strb_ctl_n = ctl; adv_n = adv;
        en_a_n = ea; en_b = eb; en_c_n = ec; wr_n = w; ext_addr = AW'(a);
        @(posedge clk); #2;
        compare();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #2;
        cyc(0, 0, 0, 0, 1, 0, 0, 'h155);   // strobes during reset
        // R10 reset state
        check("R10", desel && !cyc_valid && !cyc_write && cur_addr == 0,
              {desel, cyc_valid, cyc_write}, 3'b100);
        rst_n = 1'b1;
        // R2 processor load ignores write control, interleaved start ..01
        seq_il = 1'b1;
        cyc(0, 1, 1, 0, 1, 0, 0, 'h2A5);
        check("R2", cur_addr == 'h2A5 && !cyc_write, int'(cur_addr), 'h2A5);
        // R6 interleaved steps: 01 -> 00 -> 11 -> 10, R9 wrap back to start
        cyc(1, 1, 0, 0, 1, 0, 1, 0);
        check("R6", cur_addr == 'h2A4, int'(cur_addr), 'h2A4);
        cyc(1, 1, 0, 1, 0, 1, 1, 0);        // R11 enables off while stepping
        cyc(1, 1, 1, 1, 0, 1, 1, 0);        // R8 hold
        check("R8", cur_addr == 'h2A7, int'(cur_addr), 'h2A7);
        cyc(0, 1, 0, 1, 1, 0, 1, 0);        // R5 processor strobe ignored
        check("R5", cur_addr == 'h2A6 && cyc_valid, int'(cur_addr), 'h2A6);
        cyc(1, 1, 0, 0, 1, 0, 1, 0);
        check("R9", cur_addr == 'h2A5, int'(cur_addr), 'h2A5);
        // R3 controller load, write, linear from ..11
        seq_il = 1'b0;
        cyc(1, 0, 1, 0, 1, 0, 0, 'h3F0B);
        check("R3", cur_addr == 'h3F0B && cyc_write, int'(cur_addr), 'h3F0B);
        cyc(1, 1, 0, 0, 1, 0, 1, 0);
        check("R7", cur_addr == 'h3F08, int'(cur_addr), 'h3F08);
        cyc(1, 1, 0, 0, 1, 0, 1, 0);
        check("R7", cur_addr == 'h3F09, int'(cur_addr), 'h3F09);
        // R1 one enable wrong while the processor strobe is low
        cyc(0, 1, 0, 0, 0, 0, 1, 'h1);
        check("R1", desel && !cyc_valid, desel, 1);
        // R4 deselect persists through steps and holds
        cyc(1, 1, 0, 0, 1, 0, 1, 0);
        cyc(1, 1, 1, 0, 1, 0, 1, 0);
        check("R4", desel && cur_addr == 'h3F0B, int'(cur_addr), 'h3F0B);
        // R4 controller strobe with primary enable off
        cyc(1, 0, 1, 0, 1, 0, 1, 'h40);
        cyc(1, 0, 1, 1, 1, 0, 1, 'h44);
        check("R4", desel, desel, 1);
        cyc(1, 0, 1, 0, 1, 0, 1, 'h44);     // R3 read load
        check("R3", !cyc_write && cyc_valid, cyc_write, 0);
        // random phase; order select changes only with a controller load
        for (int i = 0; i < 3000; i++) begin
            bit [9:0] r;
            r = 10'($urandom);
            if (r[9:7] == 0) begin
                seq_il = $urandom % 2;
                cyc(1, 0, r[0], 0, 1, 0, r[1], int'($urandom % (1 << AW)));
            end else begin
                cyc(r[0], r[1] | r[2], r[3], r[4] & r[5], r[6] | r[7], r[8] & r[9],
                    r[2], int'($urandom % (1 << AW)));
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule